// File: doc/BRIEF.md
# Serial LSB-First Pattern Detector

This block watches a one-bit serial stream and raises a detect flag when the four-bit value 1011 has been received, with that value transmitted least significant bit first. One bit is taken on every rising clock edge, so the bits of a valid match arrive in the order 1, 1, 0, 1 on consecutive cycles.

The block is a Moore state machine with five named states:
- `ST_IDLE`: nothing matched yet.
- `ST_SEEN_1`: the first 1 has arrived.
- `ST_SEEN_11`: 1, 1 have arrived.
- `ST_SEEN_110`: 1, 1, 0 have arrived.
- `ST_MATCH`: the full pattern has arrived.

The transitions are:
- From `ST_IDLE`: 1 goes to `ST_SEEN_1`; 0 stays.
- From `ST_SEEN_1`: 1 goes to `ST_SEEN_11`; 0 returns to `ST_IDLE`.
- From `ST_SEEN_11`: 0 goes to `ST_SEEN_110`; 1 stays, because the last two ones still form a valid start.
- From `ST_SEEN_110`: 1 goes to `ST_MATCH`; 0 returns to `ST_IDLE`.
- From `ST_MATCH`: the state is left as `ST_IDLE` would be, so 1 goes to `ST_SEEN_1` and 0 goes to `ST_IDLE`.

Matching is non-overlapping. After a match the search starts fresh, and no bit of the completed match counts toward the next one. The detect output is a registered function of the state alone.

Top module: `lsb_pattern_detector`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the machine enters `ST_IDLE` and `hit` is 0 after that edge.
- R2: When the bits 1, 1, 0, 1 are sampled on four consecutive rising edges, starting from `ST_IDLE`, `hit` is 1 after the edge that samples the fourth bit.
- R3: `hit` is high for exactly one clock cycle per match.
- R4: Matches never overlap. After a match, the stream 1, 0, 1 does not raise `hit` (1101101 gives one detection, not two), and two detections are at least four cycles apart.
- R5: On a mismatch the machine keeps the longest start of 1,1,0,1 that the received bits still form. In particular, 1,1,1,0,1 raises `hit` after its fifth bit.
- R6: A 0 received in `ST_SEEN_1` or `ST_SEEN_110` drops all partial credit. For example, 1,1,0,0,1,1,0,1 raises `hit` only after its eighth bit.
- R7: The most-significant-first order 1,0,1,1, sent from `ST_IDLE`, does not raise `hit`.
- R8: Matches sent back to back (1101 1101) raise `hit` after the fourth and after the eighth bit.
- R9: A reset in the middle of a partial match discards it. After 1,1,0, then reset, then 1, `hit` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit, sampled on each rising edge |
| hit | output | 1 | Registered detect flag, high for the cycle after the final pattern bit is sampled |

## Verification
Each result of this block is due one edge after its stimulus. The bit that completes a match is sampled on a rising edge, and `hit` is valid after that same edge. A reset clears `hit` on the edge where `rst` is seen high. The bench drives each bit at a falling edge and lets one rising edge pass. It compares `hit` at the next falling edge with a model that keeps the bits received since the last restart and flags when the newest four of them are 1,1,0,1. Directed sequences cover the fallback, overlap, back-to-back and mid-pattern reset cases, and a long seeded random stream biased toward ones follows them.

// File: rtl/lpd_pkg.sv
package lpd_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_SEEN_1   = 3'd1,
        ST_SEEN_11  = 3'd2,
        ST_SEEN_110 = 3'd3,
        ST_MATCH    = 3'd4
    } lpd_state_e;

endpackage

// File: rtl/lpd_next_state.sv
module lpd_next_state
    import lpd_pkg::*;
(
    input  lpd_state_e cur,
    input  logic       bit_in,
    output lpd_state_e nxt
);

    always_comb begin
        nxt = ST_IDLE;
        unique case (cur)
            ST_IDLE:     nxt = bit_in ? ST_SEEN_1   : ST_IDLE;
            ST_SEEN_1:   nxt = bit_in ? ST_SEEN_11  : ST_IDLE;
            // an extra 1 keeps the two newest ones as a valid start
            ST_SEEN_11:  nxt = bit_in ? ST_SEEN_11  : ST_SEEN_110;
            ST_SEEN_110: nxt = bit_in ? ST_MATCH    : ST_IDLE;
            // non-overlapping: behave exactly as from idle
            ST_MATCH:    nxt = bit_in ? ST_SEEN_1   : ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/lpd_state_reg.sv
module lpd_state_reg
    import lpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpd_state_e nxt,
    output lpd_state_e cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= ST_IDLE;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/lpd_output_reg.sv
module lpd_output_reg
    import lpd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  lpd_state_e nxt,
    output logic       flag
);

    // registered copy of the Moore decode, aligned with the state register
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else begin
            flag <= (nxt == ST_MATCH);
        end
    end

endmodule

// File: rtl/lsb_pattern_detector.sv
module lsb_pattern_detector
    import lpd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    output logic hit
);

    lpd_state_e state_q;
    lpd_state_e state_d;

    lpd_next_state u_next (
        .cur    (state_q),
        .bit_in (ser_in),
        .nxt    (state_d)
    );

    lpd_state_reg u_state (
        .clk (clk),
        .rst (rst),
        .nxt (state_d),
        .cur (state_q)
    );

    lpd_output_reg u_out (
        .clk  (clk),
        .rst  (rst),
        .nxt  (state_d),
        .flag (hit)
    );

endmodule

// File: rtl/lpd_checker.sv
module lpd_checker (
    input logic clk,
    input logic rst,
    input logic ser_in,
    input logic hit
);

    AST_RESET_CLEARS_HIT: assert property (@(posedge clk) rst |=> !hit); // R1

    AST_HIT_AFTER_PATTERN: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(ser_in, 1) && !$past(ser_in, 2) && $past(ser_in, 3) && $past(ser_in, 4))); // R2

    AST_HIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit); // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        hit |-> (!$past(hit, 1) && !$past(hit, 2) && !$past(hit, 3))); // R4

endmodule

bind lsb_pattern_detector lpd_checker u_lpd_checker (
    .clk    (clk),
    .rst    (rst),
    .ser_in (ser_in),
    .hit    (hit)
);

// File: tb/lsb_pattern_detector_tb.sv
module lsb_pattern_detector_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic hit;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [3:0] hist = 4'b0;
    int since_restart = 0;

    always #10 clk = ~clk;

    lsb_pattern_detector u_dut (
        .clk    (clk),
        .rst    (rst),
        .ser_in (ser_in),
        .hit    (hit)
    );

    function automatic logic model_step(input logic b);
        logic m;
        hist = {hist[2:0], b};
        since_restart++;
        m = (since_restart >= 4) && (hist == 4'b1101);
        if (m) since_restart = 0;
        return m;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: hit=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send(input logic b, input string req);
        logic e;
        ser_in = b;
        @(posedge clk);
        @(negedge clk);
        e = model_step(b);
        check(req, hit, e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", hit, 1'b0);
        hist = 4'b0;
        since_restart = 0;
        rst = 1'b0;
    endtask

    task automatic send_seq(input logic [15:0] bits, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) send(bits[i], req);
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R2 basic arrival order 1,1,0,1
        send_seq(16'b1101, 4, "R2");
        // R3 hit drops on the next bit
        send(1'b0, "R3");
        send(1'b0, "R3");
        // R4 no overlap: 1101 then 101
        do_reset();
        send_seq(16'b1101101, 7, "R4");
        // R5 fallback on extra ones
        do_reset();
        send_seq(16'b11101, 5, "R5");
        send_seq(16'b111101, 6, "R5");
        // R6 zero drops credit
        do_reset();
        send_seq(16'b11001101, 8, "R6");
        send_seq(16'b101101, 6, "R6");
        // R7 msb-first order from idle
        do_reset();
        send_seq(16'b1011, 4, "R7");
        // R8 back to back
        do_reset();
        send_seq(16'b11011101, 8, "R8");
        // R9 reset mid-pattern
        do_reset();
        send_seq(16'b110, 3, "R9");
        do_reset();
        send(1'b1, "R9");
        send(1'b0, "R9");
        // seeded random stream biased toward ones
        do_reset();
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            send(($urandom % 4) != 0, "R2");
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule